// File: doc/BRIEF.md
# Serial Master Burst Unloader

This block empties a sample buffer over a serial link where it acts as the master. While the `dump` level is held high, it drives a serial clock that it divides down from the master clock. It reads words from the buffer and shifts each one out on a data line, with a one-period frame marker on each word's first bit. A burst ends on its own when the buffer has nothing left. When `dump` drops, the block stops at once.

The serial clock runs in fixed relation to the edge that samples `dump` high; that edge is called edge 0 below. The clock first rises 5 master cycles later. The first word goes out on the first serial rising edge that is at least 15 master cycles after edge 0. The block requests each following word one serial period before the current word's last bit, so words follow each other with no gap. When a word slot comes up and no word is waiting, the clock runs one more full period and then stays low until the next burst.

The controller has five states. IDLE waits for `dump`. LEAD counts master cycles up to the first serial edge. RUN toggles the clock and shifts words. TAIL gives the single closing clock period. DONE keeps every output low until `dump` falls. The transitions are:
- IDLE→LEAD when `dump` is high.
- LEAD→RUN at the lead-in count.
- RUN→TAIL at a word slot with no word waiting.
- TAIL→DONE on the falling edge of the closing period.
- DONE→IDLE when `dump` is low.
- LEAD, RUN and TAIL each go to IDLE whenever `dump` is low.

Top module: `unl_burst_unloader`

## Requirements
- R1: While `rst_n` is low, and right after it is released with `dump` low, `sclk`, `sdfs`, `sdo` and `buf_rd` are all low.
- R2: The edge that first samples `dump` high in IDLE is edge 0. `sclk` stays low until edge 5 and rises at edge 5.
- R3: The serial period is 2×(`div_cfg`+1) master cycles, with the high half first. `div_cfg` is captured at edge 0, and later changes to it have no effect on the burst.
- R4: `sdfs` is high for exactly one serial period. It starts with the rising edge that carries each word's first bit. The first word starts on the first serial rising edge at or after edge 15.
- R5: Each word goes out MSB first on `sdo`. Each bit is held for one serial period, starting at a serial rising edge. `sdo` is low whenever no word is being shifted.
- R6: `buf_rd` is a one-cycle pulse. It is issued at edge 0 if `buf_empty` is low, and at the rising edge that starts bit 1 of each word if `buf_empty` is low at that edge. `buf_data` must hold the requested word from the cycle after the pulse until the next pulse.
- R7: Word i+1 starts on the serial rising edge right after word i's last bit, with no idle period between them.
- R8: At a word slot with no word fetched, `sclk` completes one more full period from that rising edge. After that, `sclk`, `sdfs` and `sdo` stay low.
- R9: If `dump` is low at an edge while the block is busy, all four outputs are low after that edge. A later burst runs normally.
- R10: If `buf_empty` is high at edge 0, no read is issued and `sdfs` never rises. `sclk` toggles from edge 5 through the extra period of the first slot and then stops.
- R11: After a burst finishes with `dump` still high, the outputs stay low and no new burst starts until `dump` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dump | input | 1 | Burst enable level |
| div_cfg | input | DIV_W | Divider setting; serial period = 2×(div_cfg+1) |
| buf_empty | input | 1 | Buffer has no word left |
| buf_data | input | WORD_W | Word returned the cycle after a read strobe |
| sclk | output | 1 | Serial clock, parked low between bursts |
| sdfs | output | 1 | Frame marker on each word's first bit |
| sdo | output | 1 | Serial data, MSB first |
| buf_rd | output | 1 | One-cycle buffer read strobe |

## Verification
A wrong lead-in or offset count shifts the first `sclk` rise or the first `sdfs` pulse by whole master cycles. It is visible within the first 20 or so cycles of every burst. A wrong bit counter or pending-word flag shows up within a word time as a misplaced `sdfs`, a repeated or missing word, or a `buf_rd` at the wrong edge. A wrong exit from RUN or TAIL shows as an `sclk` that does not park or parks a period early. The bench compares all four outputs every cycle against arithmetic expectations across all divider settings and buffer depths from zero to three words, so such faults appear at the first cycle they affect.

// File: rtl/unl_pkg.sv
package unl_pkg;

    // Burst controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_RUN,
        ST_TAIL,
        ST_DONE
    } unl_state_e;

endpackage

// File: rtl/unl_sclk_gen.sv
module unl_sclk_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             load_div,
    input  logic [DIV_W-1:0] div_in,
    input  logic             start,
    input  logic             active,
    output logic             sclk,
    output logic             rise_now,
    output logic             fall_now
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] hc;
    logic [CNT_W-1:0] half;
    logic             tick;

    assign half     = {1'b0, div_q} + CNT_W'(1);
    assign tick     = active && (hc == half);
    assign rise_now = tick && !sclk;
    assign fall_now = tick && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            hc    <= '0;
            sclk  <= 1'b0;
        end else begin
            if (load_div) begin
                div_q <= div_in;
            end
            if (halt) begin
                sclk <= 1'b0;
                hc   <= '0;
            end else if (start) begin
                sclk <= 1'b1;
                hc   <= CNT_W'(1);
            end else if (tick) begin
                sclk <= ~sclk;
                hc   <= CNT_W'(1);
            end else if (active) begin
                hc   <= hc + CNT_W'(1);
            end
        end
    end

    // R3: half-period counter never runs past the latched half period
    a_r3_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (hc <= half) && (hc != '0));

endmodule

// File: rtl/unl_word_shift.sv
module unl_word_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_in,
    output logic              sdo,
    output logic              sdfs,
    output logic              last_bit,
    output logic              fetch_pt
);
    localparam int BC_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] shreg;
    logic [BC_W-1:0]   bc;

    assign sdo      = shreg[WORD_W-1];
    assign last_bit = (bc == '0);
    assign fetch_pt = (load && (WORD_W == 2)) || (shift && (int'(bc) == 2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            bc    <= '0;
            sdfs  <= 1'b0;
        end else if (clr) begin
            shreg <= '0;
            bc    <= '0;
            sdfs  <= 1'b0;
        end else if (load) begin
            shreg <= word_in;
            bc    <= BC_W'(WORD_W - 1);
            sdfs  <= 1'b1;
        end else if (shift) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            bc    <= bc - BC_W'(1);
            sdfs  <= 1'b0;
        end
    end

    // R7: a new word is only loaded once the previous word's last bit is out
    a_r7_load_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (sdfs && !$past(sdfs)) |-> ($past(bc) == '0));

endmodule

// File: rtl/unl_burst_unloader.sv
module unl_burst_unloader
    import unl_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int DIV_W    = 3,
    parameter int SCLK_OFF = 5,
    parameter int FS_OFF   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dump,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              buf_empty,
    input  logic [WORD_W-1:0] buf_data,
    output logic              sclk,
    output logic              sdfs,
    output logic              sdo,
    output logic              buf_rd
);
    localparam int OFF_W = $clog2(FS_OFF + 1);

    unl_state_e       state, state_nx;
    logic [OFF_W-1:0] off_q;
    logic             pending;
    logic             started;

    logic halt, start_cond, lead_done, off_ge;
    logic rise_now, fall_now, last_bit, fetch_pt;
    logic boundary, word_go, tail_go, shift_go, fetch_now;
    logic clk_active;

    assign halt       = (state != ST_IDLE) && !dump;
    assign start_cond = (state == ST_IDLE) && dump;
    assign lead_done  = (state == ST_LEAD) && (off_q == OFF_W'(SCLK_OFF));
    assign off_ge     = (off_q >= OFF_W'(FS_OFF));
    assign clk_active = (state == ST_RUN) || (state == ST_TAIL);

    assign boundary  = (state == ST_RUN) && rise_now && (started ? last_bit : off_ge);
    assign word_go   = boundary && pending && !halt;
    assign tail_go   = boundary && !pending && !halt;
    assign shift_go  = (state == ST_RUN) && rise_now && started && !last_bit && !halt;
    assign fetch_now = (start_cond || (fetch_pt && !halt)) && !buf_empty;

    // Serial clock generator
    unl_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .load_div (start_cond),
        .div_in   (div_cfg),
        .start    (lead_done && !halt),
        .active   (clk_active),
        .sclk     (sclk),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    // Word shifter and frame marker
    unl_word_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (halt || tail_go || start_cond),
        .load     (word_go),
        .shift    (shift_go),
        .word_in  (buf_data),
        .sdo      (sdo),
        .sdfs     (sdfs),
        .last_bit (last_bit),
        .fetch_pt (fetch_pt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (dump)      state_nx = ST_LEAD;
            ST_LEAD: if (halt)      state_nx = ST_IDLE;
                     else if (lead_done) state_nx = ST_RUN;
            ST_RUN:  if (halt)      state_nx = ST_IDLE;
                     else if (tail_go)   state_nx = ST_TAIL;
            ST_TAIL: if (halt)      state_nx = ST_IDLE;
                     else if (fall_now)  state_nx = ST_DONE;
            ST_DONE: if (!dump)     state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // Output and bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            pending <= 1'b0;
            started <= 1'b0;
            buf_rd  <= 1'b0;
        end else if (halt) begin
            pending <= 1'b0;
            started <= 1'b0;
            buf_rd  <= 1'b0;
        end else begin
            buf_rd <= fetch_now;
            if (start_cond) begin
                off_q <= OFF_W'(1);
            end else if ((state != ST_IDLE) && (off_q < OFF_W'(FS_OFF))) begin
                off_q <= off_q + OFF_W'(1);
            end
            if (fetch_now) begin
                pending <= 1'b1;
            end else if (word_go || start_cond) begin
                pending <= 1'b0;
            end
            if (start_cond) begin
                started <= 1'b0;
            end else if (word_go) begin
                started <= 1'b1;
            end
        end
    end

    // R2: no serial clock before the lead-in completes
    a_r2_quiet_lead: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) || (state == ST_LEAD)) |-> !sclk);

    // R4: the frame marker rises together with the serial clock
    a_r4_fs_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdfs) |-> $rose(sclk));

    // R5: data only moves on a serial rising edge or on an abort
    a_r5_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> ($rose(sclk) || !$past(dump)));

    // R6: read strobe is a single cycle and never issued against an empty buffer
    a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> !buf_rd);
    a_r6_rd_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> !$past(buf_empty));

    // R8 / R11: parked outputs after a finished burst
    a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (!sclk && !sdfs && !sdo));

    // R9: dropping dump while busy clears every output at the next edge
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) != ST_IDLE) && !$past(dump)) |-> (!sclk && !sdfs && !sdo && !buf_rd));

endmodule

// File: tb/unl_burst_unloader_bench.sv
module unl_burst_unloader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int DW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dump = 1'b0;
    logic [DW-1:0] div_cfg = '0;
    logic          buf_empty;
    logic [W-1:0]  buf_data = '0;
    logic          sclk, sdfs, sdo, buf_rd;

    int  tests = 0;
    int  fails = 0;
    int  rp = 0;
    int  n_words = 0;
    int  seed = 0;
    logic ptr_rst = 1'b0;
    int  cyc = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unl_burst_unloader #(.WORD_W(W), .DIV_W(DW)) u_unl_burst_unloader (
        .clk       (clk),
        .rst_n     (rst_n),
        .dump      (dump),
        .div_cfg   (div_cfg),
        .buf_empty (buf_empty),
        .buf_data  (buf_data),
        .sclk      (sclk),
        .sdfs      (sdfs),
        .sdo       (sdo),
        .buf_rd    (buf_rd)
    );

    function automatic logic [W-1:0] pat(int s, int i);
        return W'((i * 7 + s * 3 + 5) % 16);
    endfunction

    // Buffer model: word appears the cycle after the strobe
    assign buf_empty = (rp >= n_words);
    always @(posedge clk) begin
        if (ptr_rst) begin
            rp <= 0;
        end else if (buf_rd) begin
            buf_data <= pat(seed, rp);
            rp       <= rp + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            fails = fails + 1;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic prep(int n, int s);
        @(negedge clk);
        n_words = n;
        seed    = s;
        ptr_rst = 1'b1;
        @(negedge clk);
        ptr_rst = 1'b0;
    endtask

    task automatic run_burst(int cfg, int n);
        int h, r, s0, t, last;
        h    = cfg + 1;
        r    = 2 * h;
        s0   = 5 + ((10 + r - 1) / r) * r;
        t    = s0 + n * W * r;
        last = t + h + 4;
        prep(n, cfg * 4 + n);
        dump    = 1'b1;
        div_cfg = DW'(cfg);
        @(negedge clk);
        div_cfg = ~DW'(cfg);   // R3: must be ignored after edge 0
        for (int k = 0; k <= last; k++) begin
            logic e_sclk, e_fs, e_sdo, e_rd;
            string tg;
            int    i, b;
            e_sclk = (k >= 5 && k < t + h) ? (((k - 5) % r) < h) : 1'b0;
            e_fs   = (k >= s0 && k < t) && (((k - s0) % (W * r)) < r);
            e_sdo  = 1'b0;
            i      = 0;
            if (k >= s0 && k < t) begin
                logic [W-1:0] wd;
                i     = (k - s0) / (W * r);
                b     = W - 1 - ((k - s0) % (W * r)) / r;
                wd    = pat(cfg * 4 + n, i);
                e_sdo = wd[b];
            end
            e_rd = (k == 0 && n > 0);
            for (int j = 0; j < n - 1; j++)
                if (k == s0 + j * W * r + (W - 2) * r) e_rd = 1'b1;
            if (k < 5)           tg = "R2";
            else if (k >= t + h) tg = (k >= t + h + 2) ? "R11" : ((n == 0) ? "R10" : "R8");
            else                 tg = "R3";
            chk(tg, "sclk", sclk, e_sclk);
            chk((n == 0) ? "R10" : "R4", "sdfs", sdfs, e_fs);
            chk((i > 0) ? "R7" : "R5", "sdo", sdo, e_sdo);
            chk("R6", "buf_rd", buf_rd, e_rd);
            @(negedge clk);
        end
        dump = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2);
        @(negedge clk);
        chk("R1", "sclk", sclk, 1'b0);
        chk("R1", "sdfs", sdfs, 1'b0);
        chk("R1", "sdo", sdo, 1'b0);
        chk("R1", "buf_rd", buf_rd, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "sclk idle", sclk, 1'b0);
        chk("R1", "buf_rd idle", buf_rd, 1'b0);

        // R9: abort mid-word at the edge that would fetch word 1
        prep(3, 99);
        dump    = 1'b1;
        div_cfg = DW'(1);
        @(negedge clk);
        for (int k = 0; k < 24; k++) @(negedge clk);
        dump = 1'b0;            // edge 25 samples dump low
        @(negedge clk);
        chk("R9", "sclk", sclk, 1'b0);
        chk("R9", "sdfs", sdfs, 1'b0);
        chk("R9", "sdo", sdo, 1'b0);
        chk("R9", "buf_rd", buf_rd, 1'b0);
        @(negedge clk);
        chk("R9", "sclk stays", sclk, 1'b0);

        // Sweep all divider settings and buffer depths 0..3
        for (int c = 0; c < 8; c++)
            for (int n = 0; n < 4; n++)
                run_burst(c, n);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule